// File: doc/BRIEF.md
# Addressed Serial Tuner Control Interface

This block is the register front end of a frequency synthesiser. It is a two-wire serial slave that follows the I2C bus protocol in standard and fast mode. It works on oversampled copies of SCL and SDA taken in the system clock domain, and it answers to one of four bus addresses, which an external address-select input picks. The block holds a 15-bit divide word and a set of control fields, and these drive the rest of the synthesiser directly. Those fields are the reference divider code, the charge-pump current code, the reference output enable and select bits, two test-mode bits and four open-drain port bits.

In a write, every data byte after the address is classified by its most significant bit. A byte that starts with 0 is the high half of the divide word, and the byte after it is the low half. A byte that starts with 1 is the first control byte, and the byte after it is the second control byte. Any number of such pairs may follow one address, up to STOP. The divide word never shows a half-updated value: it changes when the low half arrives, or when a STOP commits a pending high half.

In a read, the block returns a status byte. Its top bit is a power-on flag and the next bit is the lock flag. A master that does not acknowledge a status byte ends the read as if a STOP had been seen.

Top module: `tuner_ctrl_if`

## Requirements
- R1: The address byte is 1,1,0,0,0,A1,A0,RW, sent MSB first. The slave acknowledges it only when A1,A0 equal addr_sel_i[1:0]; RW=0 selects write and RW=1 selects read. Any other address is left unacknowledged and the rest of the transfer is ignored.
- R2: In a write, the slave pulls SDA low in the acknowledge slot of every data byte it receives.
- R3: A data byte whose bit 7 is 0 carries divide bits 14..8 in its bits 6..0. The next byte carries divide bits 7..0. When that byte completes, div_word_o takes all 15 bits at once.
- R4: A data byte whose bit 7 is 1 is laid out as {1, T1, T0, R4..R0}. On receipt it loads test_mode_o={T1,T0} and ref_code_o=R4..R0. The next byte is laid out as {C1, C0, RE, RS, P3, P2, P1, P0}. It loads cp_code_o, out_en_o=RE, out_sel_o=RS and the port bits (1 = port sinking, 0 = off).
- R5: After a pair completes, further pairs are accepted without a new address, and each is classified again by its leading bit. A new address always restarts the classification.
- R6: A divide high byte that has no low byte after it leaves div_word_o unchanged until STOP. STOP then loads bits 14..8 and keeps bits 7..0. A STOP in the middle of a byte discards that partial byte.
- R7: After reset, div_word_o=0, ref_code_o=0, cp_code_o=0, test_mode_o=00, out_en_o=1, out_sel_o=1, port_o=0000, and SDA is released.
- R8: The read status byte is {POR, FL, 000000}, MSB first. FL equals lock_i when test_mode_o is 00. FL is 0 when test_mode_o is 01 or 10, and 1 when it is 11.
- R9: POR is 1 after reset. It is cleared when a read transfer ends, either by STOP or by a missing acknowledge, and it stays 1 through any number of earlier acknowledged status bytes.
- R10: If the master leaves SDA high in a status acknowledge slot, the slave stops driving the bus until the next START.
- R11: When test_mode_o=01, out_en_o=0 and out_sel_o=1, port_o[0] follows fpd_div2_i. Otherwise port_o[0] is the stored P0 bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel_i | input | 2 | Variable address bits A1,A0 |
| lock_i | input | 1 | Phase lock indication |
| fpd_div2_i | input | 1 | Programmable divider output divided by two |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| div_word_o | output | 15 | Programmable divide word |
| ref_code_o | output | 5 | Reference divider code |
| cp_code_o | output | 2 | Charge-pump current code |
| out_en_o | output | 1 | Reference output enable |
| out_sel_o | output | 1 | Reference output select |
| test_mode_o | output | 2 | Test mode bits |
| port_o | output | 4 | Port sink enables |

## Verification
SCL and SDA each pass through two synchroniser flops and one edge-detect flop, and the state machine adds one more register. So every bus-driven result — an acknowledge, a data bit, a register load or a STOP commit — appears three to four clocks after the line edge that causes it. The bench keeps each SCL phase at eight clocks and changes SDA four clocks into the low phase. It samples the line in the middle of the high phase and reads register outputs at least eight clocks after the STOP edge, so every sample falls well after that latency. The port_o[0] bypass of R11 is combinational and is checked one clock after fpd_div2_i changes.

// File: rtl/tuner_pkg.sv
package tuner_pkg;
  localparam logic [4:0] ADDR_FIXED = 5'b11000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_ACK
  } slv_state_e;

  typedef enum logic [1:0] {
    TM_NORMAL = 2'b00,
    TM_P0_FPD = 2'b01,
    TM_SINK   = 2'b10,
    TM_OFF    = 2'b11
  } test_mode_e;
endpackage

// File: rtl/tuner_bus_sync.sv
module tuner_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_o      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edges while SCL stays high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/tuner_i2c_slave.sv
module tuner_i2c_slave
  import tuner_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [1:0]        addr_sel_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              sda_pull_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              addr_hit_o,
  output logic              read_done_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  slv_state_e        state_q;
  logic [BYTE_W-1:0] sr_q, tx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pull_q, rw_q, in_read_q;
  logic              addr_match;

  assign addr_match = (sr_q[BYTE_W-1:1] == {ADDR_FIXED, addr_sel_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sr_q        <= '0;
      tx_q        <= '0;
      cnt_q       <= '0;
      pull_q      <= 1'b0;
      rw_q        <= 1'b0;
      in_read_q   <= 1'b0;
      rx_valid_o  <= 1'b0;
      rx_byte_o   <= '0;
      addr_hit_o  <= 1'b0;
      read_done_o <= 1'b0;
    end else begin
      rx_valid_o  <= 1'b0;
      addr_hit_o  <= 1'b0;
      read_done_o <= 1'b0;
      if (start_i) begin
        state_q   <= ST_ADDR;
        cnt_q     <= '0;
        pull_q    <= 1'b0;
        in_read_q <= 1'b0;
      end else if (stop_i) begin
        state_q     <= ST_IDLE;
        pull_q      <= 1'b0;
        read_done_o <= in_read_q;
        in_read_q   <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WR_DATA: begin
            if (scl_rise_i) begin
              sr_q  <= {sr_q[BYTE_W-2:0], sda_s_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == FULL) begin
              if (state_q == ST_WR_DATA) begin
                rx_valid_o <= 1'b1;
                rx_byte_o  <= sr_q;
                pull_q     <= 1'b1;
                state_q    <= ST_WR_ACK;
              end else if (addr_match) begin
                rw_q       <= sr_q[0];
                addr_hit_o <= 1'b1;
                pull_q     <= 1'b1;
                state_q    <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rw_q) begin
                tx_q      <= status_i;
                pull_q    <= ~status_i[BYTE_W-1];
                in_read_q <= 1'b1;
                state_q   <= ST_RD_DATA;
              end else begin
                pull_q  <= 1'b0;
                state_q <= ST_WR_DATA;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              pull_q  <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_WR_DATA;
            end
          end
          ST_RD_DATA: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i) begin
              if (cnt_q == FULL) begin
                pull_q  <= 1'b0;
                state_q <= ST_RD_ACK;
              end else begin
                pull_q <= ~tx_q[BYTE_W-2];
                tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i && sda_s_i) begin
              // missing acknowledge acts as an internal STOP
              state_q     <= ST_IDLE;
              read_done_o <= 1'b1;
              in_read_q   <= 1'b0;
            end else if (scl_fall_i) begin
              tx_q    <= status_i;
              pull_q  <= ~status_i[BYTE_W-1];
              cnt_q   <= '0;
              state_q <= ST_RD_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;

  AST_ACK_SLOT_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR_ACK || state_q == ST_WR_ACK) |-> pull_q); // R2
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !pull_q); // R10
  AST_PULL_ON_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_q) |-> !scl_s_i); // R1
endmodule

// File: rtl/tuner_regs.sv
module tuner_regs
  import tuner_pkg::*;
#(
  parameter int DIV_W  = 15,
  parameter int BYTE_W = 8,
  parameter int REF_W  = 5,
  parameter int PORT_N = 4,
  localparam int HI_W  = DIV_W - BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              addr_hit_i,
  input  logic              stop_i,
  input  logic              read_done_i,
  input  logic              lock_i,
  input  logic              fpd_div2_i,
  output logic [BYTE_W-1:0] status_o,
  output logic [DIV_W-1:0]  div_word_o,
  output logic [REF_W-1:0]  ref_code_o,
  output logic [1:0]        cp_code_o,
  output logic              out_en_o,
  output logic              out_sel_o,
  output logic [1:0]        test_mode_o,
  output logic [PORT_N-1:0] port_o
);
  logic [DIV_W-1:0]  div_q;
  logic [HI_W-1:0]   hi_pend_q;
  logic              hi_pend_v_q, first_q, kind_ctl_q;
  logic [1:0]        tm_q, cp_q;
  logic [REF_W-1:0]  ref_q;
  logic              re_q, rs_q, por_q, fl;
  logic [PORT_N-1:0] port_q;
  logic [REF_W+PORT_N+6:0] ctl_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q       <= '0;
      hi_pend_q   <= '0;
      hi_pend_v_q <= 1'b0;
      first_q     <= 1'b1;
      kind_ctl_q  <= 1'b0;
      tm_q        <= TM_NORMAL;
      ref_q       <= '0;
      cp_q        <= '0;
      re_q        <= 1'b1;
      rs_q        <= 1'b1;
      port_q      <= '0;
      por_q       <= 1'b1;
    end else begin
      if (read_done_i) por_q <= 1'b0;
      if (addr_hit_i) begin
        first_q <= 1'b1;
      end else if (rx_valid_i) begin
        if (first_q) begin
          first_q    <= 1'b0;
          kind_ctl_q <= rx_byte_i[BYTE_W-1];
          if (!rx_byte_i[BYTE_W-1]) begin
            hi_pend_q   <= rx_byte_i[HI_W-1:0];
            hi_pend_v_q <= 1'b1;
          end else begin
            tm_q  <= rx_byte_i[BYTE_W-2 -: 2];
            ref_q <= rx_byte_i[REF_W-1:0];
          end
        end else begin
          first_q <= 1'b1;
          if (!kind_ctl_q) begin
            div_q       <= {hi_pend_q, rx_byte_i};
            hi_pend_v_q <= 1'b0;
          end else begin
            cp_q   <= rx_byte_i[BYTE_W-1 -: 2];
            re_q   <= rx_byte_i[BYTE_W-3];
            rs_q   <= rx_byte_i[BYTE_W-4];
            port_q <= rx_byte_i[PORT_N-1:0];
          end
        end
      end else if (stop_i && hi_pend_v_q) begin
        div_q[DIV_W-1:BYTE_W] <= hi_pend_q;
        hi_pend_v_q           <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (tm_q)
      TM_P0_FPD, TM_SINK: fl = 1'b0;
      TM_OFF:             fl = 1'b1;
      default:            fl = lock_i;
    endcase
  end

  assign status_o    = {por_q, fl, {(BYTE_W-2){1'b0}}};
  assign div_word_o  = div_q;
  assign ref_code_o  = ref_q;
  assign cp_code_o   = cp_q;
  assign out_en_o    = re_q;
  assign out_sel_o   = rs_q;
  assign test_mode_o = tm_q;
  assign port_o      = {port_q[PORT_N-1:1],
                        (tm_q == TM_P0_FPD && !re_q && rs_q) ? fpd_div2_i : port_q[0]};
  assign ctl_vec     = {tm_q, ref_q, cp_q, re_q, rs_q, port_q};

  AST_DIV_ATOMIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q != $past(div_q)) |-> $past(rx_valid_i || stop_i)); // R6
  AST_CTL_ON_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_vec != $past(ctl_vec)) |-> $past(rx_valid_i)); // R4
  AST_POR_NEVER_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(por_q)); // R9
endmodule

// File: rtl/tuner_ctrl_if.sv
module tuner_ctrl_if #(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 15,
  parameter int REF_W       = 5,
  parameter int PORT_N      = 4,
  localparam int BYTE_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        addr_sel_i,
  input  logic              lock_i,
  input  logic              fpd_div2_i,
  output logic              sda_pull_o,
  output logic [DIV_W-1:0]  div_word_o,
  output logic [REF_W-1:0]  ref_code_o,
  output logic [1:0]        cp_code_o,
  output logic              out_en_o,
  output logic              out_sel_o,
  output logic [1:0]        test_mode_o,
  output logic [PORT_N-1:0] port_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic rx_valid, addr_hit, read_done;
  logic [BYTE_W-1:0] rx_byte, status;

  tuner_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  tuner_i2c_slave #(.BYTE_W(BYTE_W)) u_slave (
    .clk_i, .rst_ni,
    .scl_s_i(scl_s), .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .addr_sel_i, .status_i(status),
    .sda_pull_o, .rx_valid_o(rx_valid), .rx_byte_o(rx_byte),
    .addr_hit_o(addr_hit), .read_done_o(read_done)
  );

  tuner_regs #(.DIV_W(DIV_W), .BYTE_W(BYTE_W), .REF_W(REF_W), .PORT_N(PORT_N)) u_regs (
    .clk_i, .rst_ni,
    .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .addr_hit_i(addr_hit),
    .stop_i(stop), .read_done_i(read_done), .lock_i, .fpd_div2_i,
    .status_o(status), .div_word_o, .ref_code_o, .cp_code_o,
    .out_en_o, .out_sel_o, .test_mode_o, .port_o
  );
endmodule

// File: tb/tuner_ctrl_if_tb_top.sv
module tuner_ctrl_if_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] addr_sel = 2'd0;
  logic lock = 1'b0, fpd = 1'b0;
  logic sda_pull, sda_w;
  logic [14:0] div_word;
  logic [4:0] ref_code;
  logic [1:0] cp_code, test_mode;
  logic out_en, out_sel;
  logic [3:0] port;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_w = m_sda & ~sda_pull;

  tuner_ctrl_if dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(m_scl), .sda_i(sda_w),
    .addr_sel_i(addr_sel), .lock_i(lock), .fpd_div2_i(fpd),
    .sda_pull_o(sda_pull), .div_word_o(div_word), .ref_code_o(ref_code),
    .cp_code_o(cp_code), .out_en_o(out_en), .out_sel_o(out_sel),
    .test_mode_o(test_mode), .port_o(port)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; tick(8);
    m_sda = 1'b0; tick(8);
    m_scl = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(4);
    m_scl = 1'b1; tick(8);
    m_sda = 1'b1; tick(8);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; tick(4);
    m_scl = 1'b1; tick(8);
    m_scl = 1'b0; tick(4);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    m_sda = 1'b1; tick(4);
    m_scl = 1'b1; tick(4);
    ack = ~sda_w; tick(4);
    m_scl = 1'b0; tick(4);
  endtask

  task automatic get_byte(input logic ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(4); m_scl = 1'b1; tick(4);
      b[i] = sda_w; tick(4);
      m_scl = 1'b0;
    end
    tick(4);
    m_sda = ~ack; tick(4);
    m_scl = 1'b1; tick(8);
    m_scl = 1'b0; tick(4);
    m_sda = 1'b1;
  endtask

  function automatic logic [7:0] addr_byte(input logic [1:0] a, input logic rw);
    return {5'b11000, a, rw};
  endfunction

  // write a list of up to four bytes in one transfer, checking each acknowledge
  task automatic write_tx(input int n, input logic [7:0] b0, b1, b2, b3);
    logic ack;
    logic [7:0] bl [4];
    bl[0] = b0; bl[1] = b1; bl[2] = b2; bl[3] = b3;
    bus_start();
    put_byte(addr_byte(addr_sel, 1'b0), ack);
    chk("R1 write address ack", 32'(ack), 32'd1);
    for (int i = 0; i < n; i++) begin
      put_byte(bl[i], ack);
      chk("R2 data byte ack", 32'(ack), 32'd1);
    end
    bus_stop();
    tick(8);
  endtask

  task automatic read_status(output logic [7:0] s);
    logic ack;
    bus_start();
    put_byte(addr_byte(addr_sel, 1'b1), ack);
    chk("R1 read address ack", 32'(ack), 32'd1);
    get_byte(1'b0, s);
    bus_stop();
    tick(8);
  endtask

  initial begin
    logic ack;
    logic [7:0] s, s2;
    logic [14:0] exp_div, v;
    tick(5);
    chk("R7 reset sda released", 32'(sda_pull), 32'd0);
    rst_ni = 1'b1;
    tick(5);
    chk("R7 reset div", 32'(div_word), 32'd0);
    chk("R7 reset ctrl", 32'({ref_code, cp_code, test_mode, out_en, out_sel, port}),
        32'({5'd0, 2'd0, 2'd0, 1'b1, 1'b1, 4'd0}));

    // R9: POR held over an acknowledged byte, cleared by a missing acknowledge
    bus_start();
    put_byte(addr_byte(2'd0, 1'b1), ack);
    chk("R1 read ack", 32'(ack), 32'd1);
    get_byte(1'b1, s);
    get_byte(1'b0, s2);
    chk("R9 por first byte", 32'(s[7]), 32'd1);
    chk("R9 por second byte", 32'(s2[7]), 32'd1);
    chk("R8 low bits zero", 32'(s[5:0]), 32'd0);
    // R10: after the missing acknowledge the line stays released
    get_byte(1'b0, s2);
    chk("R10 bus released after nack", 32'(s2), 32'hFF);
    bus_stop();
    tick(8);
    read_status(s);
    chk("R9 por cleared", 32'(s[7]), 32'd0);

    // R1: address sweep
    for (int sel = 0; sel < 4; sel++) begin
      addr_sel = 2'(sel);
      for (int a = 0; a < 4; a++) begin
        bus_start();
        put_byte(addr_byte(2'(a), 1'b0), ack);
        chk("R1 address match", 32'(ack), 32'(a == sel));
        bus_stop();
      end
    end
    bus_start();
    put_byte(8'hA0, ack);
    chk("R1 fixed part mismatch", 32'(ack), 32'd0);
    put_byte(8'h7F, ack);
    chk("R1 ignored after mismatch", 32'(ack), 32'd0);
    bus_stop();
    tick(8);
    chk("R1 no load after mismatch", 32'(div_word), 32'd0);
    addr_sel = 2'd2;

    // R3: divide word sweep
    for (int i = 0; i < 10; i++) begin
      v = (i == 9) ? 15'h7FFF : 15'((i * 32'h1357 + 32'hA5) & 32'h7FFF);
      write_tx(2, {1'b0, v[14:8]}, v[7:0], 8'h0, 8'h0);
      chk("R3 divide word", 32'(div_word), 32'(v));
    end

    // R4: control pair
    write_tx(2, {1'b1, 2'b00, 5'h15}, {2'b10, 1'b0, 1'b0, 4'b1010}, 8'h0, 8'h0);
    chk("R4 ctrl C", 32'({test_mode, ref_code}), 32'({2'b00, 5'h15}));
    chk("R4 ctrl D", 32'({cp_code, out_en, out_sel, port}), 32'({2'b10, 1'b0, 1'b0, 4'b1010}));

    // R5: several pairs, no re-addressing
    write_tx(4, {1'b1, 2'b00, 5'h0B}, {2'b01, 1'b1, 1'b1, 4'b0101}, 8'h12, 8'h34);
    chk("R5 pair ctrl", 32'({ref_code, cp_code, port}), 32'({5'h0B, 2'b01, 4'b0101}));
    chk("R5 pair div", 32'(div_word), 32'h1234);
    write_tx(4, 8'h05, 8'h67, 8'h2A, 8'hBC);
    chk("R5 two div pairs", 32'(div_word), 32'h2ABC);

    // R6: lone high byte committed only on STOP
    exp_div = {7'h33, div_word[7:0]};
    bus_start();
    put_byte(addr_byte(addr_sel, 1'b0), ack);
    put_byte(8'h33, ack);
    tick(16);
    chk("R6 no commit before stop", 32'(div_word), 32'h2ABC);
    bus_stop();
    tick(8);
    chk("R6 commit on stop", 32'(div_word), 32'(exp_div));
    // R6: STOP in the middle of a byte
    exp_div = {7'h11, div_word[7:0]};
    bus_start();
    put_byte(addr_byte(addr_sel, 1'b0), ack);
    put_byte(8'h11, ack);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    tick(8);
    chk("R6 mid-byte stop keeps low half", 32'(div_word), 32'(exp_div));

    // R8: lock flag over test modes and lock values
    for (int t = 0; t < 4; t++) begin
      for (int l = 0; l < 2; l++) begin
        lock = 1'(l);
        write_tx(1, {1'b1, 2'(t), 5'h03}, 8'h0, 8'h0, 8'h0);
        read_status(s);
        chk("R8 lock flag", 32'(s[6]),
            32'((t == 0) ? l : (t == 3) ? 1 : 0));
      end
    end
    lock = 1'b0;

    // R11: P0 bypass
    write_tx(2, {1'b1, 2'b01, 5'h00}, {2'b00, 1'b0, 1'b1, 4'b0000}, 8'h0, 8'h0);
    fpd = 1'b1; tick(1);
    chk("R11 P0 follows fpd high", 32'(port[0]), 32'd1);
    fpd = 1'b0; tick(1);
    chk("R11 P0 follows fpd low", 32'(port[0]), 32'd0);
    write_tx(1, 8'h0, 8'h0, 8'h0, 8'h0);
    write_tx(2, {1'b1, 2'b01, 5'h00}, {2'b00, 1'b1, 1'b1, 4'b0000}, 8'h0, 8'h0);
    fpd = 1'b1; tick(1);
    chk("R11 no bypass when RE set", 32'(port[0]), 32'd0);
    write_tx(2, {1'b1, 2'b00, 5'h00}, {2'b00, 1'b0, 1'b1, 4'b0001}, 8'h0, 8'h0);
    fpd = 1'b0; tick(1);
    chk("R11 stored P0 in normal mode", 32'(port[0]), 32'd1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule